// File: doc/BRIEF.md
# Three-Wire Byte Handshake Transfer Engine

This block is the controller side of a byte-serial link between a host processor and a command processor. Each byte passes through an 8-bit shift register. Three active-low handshake lines pace the transfer. The host drives the in-progress line (`pb_tip_n`) and the acknowledge line (`pb_ack_n`) by writing its port. The engine drives the request line (`req_n`) back to the host.

One direction input selects which way bytes move. When the host is sending, every byte step appends the shift-register value to a packet buffer. When in-progress is released, the collected packet is handed to a consumer as a length plus a random-access read port. When the engine is answering, a response packet is first loaded into a queue. Each byte step then places the next queued byte into the shift register. Request tells the host that data is waiting, and it rises again after the last byte has been taken.

Every step produces a one-cycle shift-register interrupt strobe. The strobe comes after a parameterised delay, or on the next cycle when the port direction register reads all ones. A response load that coincides with a port write is ignored; the driving side keeps these two apart.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, `req_n` is 1, `sr_q` is 0, and `sr_irq` and `pkt_valid` are 0. The engine treats both host lines as released (1).
- R2: With `dir_to_engine`=1 and `pb_tip_n`=0 in a port write, the current `sr_q` is appended to the packet buffer when either host line differs from its value in the previous port write. A port write that changes neither line appends nothing and raises no strobe.
- R3: The packet buffer holds DEPTH bytes. Further bytes of the same packet are dropped silently, so a handed-off length never exceeds DEPTH.
- R4: A port write with `pb_tip_n`=1, made after a write that had `pb_tip_n`=0, ends the transfer and always raises a strobe. If at least one byte was collected, `pkt_valid` pulses for one cycle with `pkt_len` equal to the byte count, and the collection index returns to zero. With no bytes collected, no pulse occurs.
- R5: With `dir_to_engine`=0 and `pb_tip_n`=0, a port write that changes a host line moves the next queued response byte into `sr_q` and raises a strobe. Taking the last queued byte drives `req_n` to 1. With the queue empty, `sr_q` is unchanged.
- R6: With `pb_tip_n` at 1 in both the previous and the current port write, a change of `pb_ack_n` copies its new value to `req_n` and raises a strobe.
- R7: When a transfer ends, or a response is loaded, while `pb_tip_n` is 1 and response bytes are still queued, `req_n` is driven to 0.
- R8: When `ddr_b` is not 8'hFF, `sr_irq` pulses exactly DELAY_CYC cycles after the step that caused it. A new step before that point restarts the delay, and the earlier pulse never appears.
- R9: When `ddr_b` is 8'hFF, `sr_irq` pulses on the cycle right after the causing step.
- R10: `rsp_load` with length N sets the queue size to N and restarts reading at entry 0, even if an earlier response was only partly consumed. It also raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_b | input | 8 | Port direction register value; 8'hFF selects immediate strobes |
| dir_to_engine | input | 1 | 1: bytes flow host to engine; 0: engine to host |
| pb_wr | input | 1 | Host port write strobe |
| pb_tip_n | input | 1 | Written in-progress level (active low) |
| pb_ack_n | input | 1 | Written acknowledge level (active low) |
| req_n | output | 1 | Request line to host (active low) |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | 8 | Shift register write data |
| sr_q | output | 8 | Shift register contents |
| rsp_wr | input | 1 | Write one response queue entry |
| rsp_wr_idx | input | IDXW | Response entry index |
| rsp_wr_byte | input | 8 | Response entry data |
| rsp_load | input | 1 | Commit a response packet |
| rsp_load_len | input | IDXW+1 | Length of the committed response |
| pkt_valid | output | 1 | One-cycle pulse: host packet handed off |
| pkt_len | output | IDXW+1 | Length of the handed-off packet |
| pkt_rd_idx | input | IDXW | Packet buffer read index |
| pkt_rd_byte | output | 8 | Packet buffer byte at `pkt_rd_idx` |
| sr_irq | output | 1 | Shift-register interrupt strobe |

## Verification
The bound checker watches several rules on every cycle. A step under an all-ones direction register must strobe on the next cycle, and a handoff may only follow a release of in-progress. A handed-off length must lie between 1 and DEPTH. The shift register may move only on a port or shift-register write. Request must rise after the last queued byte and must follow acknowledge while the link is idle.

Only the bench scenarios can show the rest. These cover the exact contents and order of collected packets, including the overflow drop, and the sequence of response bytes across a reload in mid-packet. They also cover the exact delayed-strobe cycle, its restart, and the absence of a strobe on a write that changes nothing.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

   // One port-write or load evaluation, decoded into actions.
   typedef struct packed {
      logic append;    // collect sr into the packet buffer
      logic pop;       // move next response byte into sr
      logic handoff;   // end-of-packet handoff to consumer
      logic load;      // response commit accepted
      logic sched;     // schedule a shift-register strobe
      logic req_wr;    // update request line
      logic req_val;   // new request level
   } step_t;

endpackage

// File: rtl/hs_irq_timer.sv
module hs_irq_timer #(
   parameter int unsigned DELAY_CYC = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched,
   input  logic immediate,
   output logic irq
);

   logic irq_q;

   generate
      if (DELAY_CYC == 0) begin : g_nodelay
         logic unused_imm;
         assign unused_imm = immediate;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= sched;
         end
      end else begin : g_delay
         localparam int unsigned CW = $clog2(DELAY_CYC + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               irq_q <= 1'b0;
            end else if (sched) begin
               if (immediate) begin
                  cnt_q <= '0;
                  irq_q <= 1'b1;
               end else begin
                  cnt_q <= CW'(DELAY_CYC);
                  irq_q <= 1'b0;
               end
            end else begin
               irq_q <= (cnt_q == CW'(1));
               if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
            end
         end
      end
   endgenerate

   assign irq = irq_q;

endmodule

// File: rtl/hs_pkt_collector.sv
module hs_pkt_collector #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned IDXW = $clog2(DEPTH),
   localparam int unsigned CNTW = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            append,
   input  logic [7:0]      din,
   input  logic            handoff,
   output logic            full,
   output logic [CNTW-1:0] fill,
   output logic            pkt_valid,
   output logic [CNTW-1:0] pkt_len,
   input  logic [IDXW-1:0] rd_idx,
   output logic [7:0]      rd_byte
);

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 256)
         else $error("hs_pkt_collector: DEPTH %0d out of range", DEPTH);
   end

   logic [CNTW-1:0] fill_q;
   logic [7:0]      mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [7:0] ent_q;
         always_ff @(posedge clk) begin
            if (append && fill_q == CNTW'(e)) ent_q <= din;
         end
         assign mem[e] = ent_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= '0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         pkt_valid <= 1'b0;
         if (handoff) begin
            pkt_valid <= 1'b1;
            pkt_len   <= fill_q;
            fill_q    <= '0;
         end else if (append) begin
            fill_q <= fill_q + CNTW'(1);
         end
      end
   end

   assign full    = (fill_q == CNTW'(DEPTH));
   assign fill    = fill_q;
   assign rd_byte = ({1'b0, rd_idx} < CNTW'(DEPTH)) ? mem[rd_idx] : 8'h00;

endmodule

// File: rtl/hs_rsp_queue.sv
module hs_rsp_queue #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned IDXW = $clog2(DEPTH),
   localparam int unsigned CNTW = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [7:0]      wr_byte,
   input  logic            load,
   input  logic [CNTW-1:0] load_len,
   input  logic            pop,
   output logic [7:0]      head,
   output logic            pending,
   output logic            last
);

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 256)
         else $error("hs_rsp_queue: DEPTH %0d out of range", DEPTH);
   end

   logic [CNTW-1:0] size_q;
   logic [CNTW-1:0] rd_q;
   logic [7:0]      mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [7:0] ent_q;
         always_ff @(posedge clk) begin
            if (wr_en && {1'b0, wr_idx} == CNTW'(e)) ent_q <= wr_byte;
         end
         assign mem[e] = ent_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         rd_q   <= '0;
      end else if (load) begin
         size_q <= (load_len > CNTW'(DEPTH)) ? CNTW'(DEPTH) : load_len;
         rd_q   <= '0;
      end else if (pop && pending) begin
         rd_q <= rd_q + CNTW'(1);
      end
   end

   assign pending = (rd_q < size_q);
   assign last    = ((rd_q + CNTW'(1)) == size_q);
   assign head    = (rd_q < CNTW'(DEPTH)) ? mem[rd_q[IDXW-1:0]] : 8'h00;

endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
   import hs_xfer_pkg::*;
#(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned DELAY_CYC = 15000,
   localparam int unsigned IDXW = $clog2(DEPTH),
   localparam int unsigned CNTW = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      ddr_b,
   input  logic            dir_to_engine,
   input  logic            pb_wr,
   input  logic            pb_tip_n,
   input  logic            pb_ack_n,
   output logic            req_n,
   input  logic            sr_wr,
   input  logic [7:0]      sr_wdata,
   output logic [7:0]      sr_q,
   input  logic            rsp_wr,
   input  logic [IDXW-1:0] rsp_wr_idx,
   input  logic [7:0]      rsp_wr_byte,
   input  logic            rsp_load,
   input  logic [CNTW-1:0] rsp_load_len,
   output logic            pkt_valid,
   output logic [CNTW-1:0] pkt_len,
   input  logic [IDXW-1:0] pkt_rd_idx,
   output logic [7:0]      pkt_rd_byte,
   output logic            sr_irq
);

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 256)
         else $error("hs_xfer_engine: DEPTH %0d out of range", DEPTH);
   end

   // handshake history from the previous port write
   logic last_tip_n, last_ack_n;
   logic req_q;
   logic [7:0] sr_r;

   // neighbour status
   logic            col_full;
   logic [CNTW-1:0] col_fill;
   logic [7:0]      rsp_head;
   logic            rsp_pending, rsp_last;

   step_t st;
   logic  sched_w, pop_w, moved;

   always_comb begin
      st    = '0;
      moved = (pb_tip_n != last_tip_n) || (pb_ack_n != last_ack_n);
      if (pb_wr) begin
         if (!pb_tip_n) begin
            if (dir_to_engine) begin
               if (moved) begin
                  st.append = !col_full;
                  st.sched  = 1'b1;
               end
            end else if (rsp_pending && moved) begin
               st.pop   = 1'b1;
               st.sched = 1'b1;
               if (rsp_last) begin
                  st.req_wr  = 1'b1;
                  st.req_val = 1'b1;
               end
            end
         end else if (last_tip_n && (pb_ack_n != last_ack_n)) begin
            st.req_wr  = 1'b1;
            st.req_val = pb_ack_n;
            st.sched   = 1'b1;
         end else begin
            if (!last_tip_n) begin
               st.handoff = (col_fill != '0);
               st.sched   = 1'b1;
            end
            if (rsp_pending) begin
               st.req_wr  = 1'b1;
               st.req_val = 1'b0;
            end
         end
      end else if (rsp_load) begin
         st.load  = 1'b1;
         st.sched = 1'b1;
         if (last_tip_n && rsp_load_len != '0) begin
            st.req_wr  = 1'b1;
            st.req_val = 1'b0;
         end
      end
   end

   assign sched_w = st.sched;
   assign pop_w   = st.pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_tip_n <= 1'b1;
         last_ack_n <= 1'b1;
         req_q      <= 1'b1;
         sr_r       <= 8'h00;
      end else begin
         if (pb_wr) begin
            last_tip_n <= pb_tip_n;
            last_ack_n <= pb_ack_n;
         end
         if (st.req_wr) req_q <= st.req_val;
         if (st.pop)       sr_r <= rsp_head;
         else if (sr_wr)   sr_r <= sr_wdata;
      end
   end

   hs_pkt_collector #(.DEPTH(DEPTH)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .append    (st.append),
      .din       (sr_r),
      .handoff   (st.handoff),
      .full      (col_full),
      .fill      (col_fill),
      .pkt_valid (pkt_valid),
      .pkt_len   (pkt_len),
      .rd_idx    (pkt_rd_idx),
      .rd_byte   (pkt_rd_byte)
   );

   hs_rsp_queue #(.DEPTH(DEPTH)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rsp_wr),
      .wr_idx   (rsp_wr_idx),
      .wr_byte  (rsp_wr_byte),
      .load     (st.load),
      .load_len (rsp_load_len),
      .pop      (st.pop),
      .head     (rsp_head),
      .pending  (rsp_pending),
      .last     (rsp_last)
   );

   hs_irq_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .sched     (st.sched),
      .immediate (ddr_b == 8'hFF),
      .irq       (sr_irq)
   );

   assign req_n = req_q;
   assign sr_q  = sr_r;

endmodule

// File: rtl/hs_xfer_engine_chk.sv
module hs_xfer_engine_chk #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNTW = $clog2(DEPTH) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [7:0]      ddr_b,
   input logic            pb_wr,
   input logic            pb_tip_n,
   input logic            pb_ack_n,
   input logic            sr_wr,
   input logic [7:0]      sr_q,
   input logic            req_n,
   input logic            pkt_valid,
   input logic [CNTW-1:0] pkt_len,
   input logic            sr_irq,
   input logic            sched_w,
   input logic            pop_w,
   input logic            rsp_last,
   input logic            last_tip_n,
   input logic            last_ack_n
);

   p_imm_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_w && ddr_b == 8'hFF) |=> sr_irq);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len <= CNTW'(DEPTH) && pkt_len != '0));

   p_handoff_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> ($past(pb_wr) && $past(pb_tip_n) && !$past(last_tip_n)));

   p_last_byte_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_w && rsp_last) |=> req_n);

   p_sr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pb_wr && !sr_wr) |=> $stable(sr_q));

   p_req_follows_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_wr && pb_tip_n && last_tip_n && (pb_ack_n != last_ack_n))
      |=> (req_n == $past(pb_ack_n)));

endmodule

bind hs_xfer_engine hs_xfer_engine_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ddr_b      (ddr_b),
   .pb_wr      (pb_wr),
   .pb_tip_n   (pb_tip_n),
   .pb_ack_n   (pb_ack_n),
   .sr_wr      (sr_wr),
   .sr_q       (sr_q),
   .req_n      (req_n),
   .pkt_valid  (pkt_valid),
   .pkt_len    (pkt_len),
   .sr_irq     (sr_irq),
   .sched_w    (sched_w),
   .pop_w      (pop_w),
   .rsp_last   (rsp_last),
   .last_tip_n (last_tip_n),
   .last_ack_n (last_ack_n)
);

// File: tb/hs_xfer_engine_test.sv
`timescale 1ns/1ps
module hs_xfer_engine_test;

   localparam int DEPTH = 16;
   localparam int DLY   = 12;
   localparam int IDXW  = 4;
   localparam int CNTW  = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      ddr_b = 8'hFF;
   logic            dir_to_engine = 1'b0;
   logic            pb_wr = 1'b0, pb_tip_n = 1'b1, pb_ack_n = 1'b1;
   logic            req_n;
   logic            sr_wr = 1'b0;
   logic [7:0]      sr_wdata = 8'h00;
   logic [7:0]      sr_q;
   logic            rsp_wr = 1'b0;
   logic [IDXW-1:0] rsp_wr_idx = '0;
   logic [7:0]      rsp_wr_byte = 8'h00;
   logic            rsp_load = 1'b0;
   logic [CNTW-1:0] rsp_load_len = '0;
   logic            pkt_valid;
   logic [CNTW-1:0] pkt_len;
   logic [IDXW-1:0] pkt_rd_idx = '0;
   logic [7:0]      pkt_rd_byte;
   logic            sr_irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic cur_ack = 1'b1;

   int       exp_len_q[$];
   bit [7:0] exp_byte_q[$];

   always #10 clk = ~clk;

   hs_xfer_engine #(.DEPTH(DEPTH), .DELAY_CYC(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .ddr_b(ddr_b), .dir_to_engine(dir_to_engine),
      .pb_wr(pb_wr), .pb_tip_n(pb_tip_n), .pb_ack_n(pb_ack_n), .req_n(req_n),
      .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_q),
      .rsp_wr(rsp_wr), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_byte(rsp_wr_byte),
      .rsp_load(rsp_load), .rsp_load_len(rsp_load_len),
      .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .pkt_rd_idx(pkt_rd_idx), .pkt_rd_byte(pkt_rd_byte), .sr_irq(sr_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // all driver tasks start and end just after a falling edge
   task automatic pb_write(input logic tip, input logic ack);
      pb_wr = 1'b1; pb_tip_n = tip; pb_ack_n = ack;
      @(negedge clk);
      pb_wr = 1'b0;
   endtask

   task automatic sr_write(input logic [7:0] v);
      sr_wr = 1'b1; sr_wdata = v;
      @(negedge clk);
      sr_wr = 1'b0;
   endtask

   task automatic rsp_fill(input int idx, input logic [7:0] v);
      rsp_wr = 1'b1; rsp_wr_idx = IDXW'(idx); rsp_wr_byte = v;
      @(negedge clk);
      rsp_wr = 1'b0;
   endtask

   task automatic rsp_go(input int len);
      rsp_load = 1'b1; rsp_load_len = CNTW'(len);
      @(negedge clk);
      rsp_load = 1'b0;
   endtask

   task automatic toggle_idle_ack();
      cur_ack = ~cur_ack;
      pb_write(1'b1, cur_ack);
   endtask

   // driver: sends a host packet and pushes the expected result
   task automatic send_host_packet(input int n, input logic [7:0] base);
      dir_to_engine = 1'b1;
      for (int i = 0; i < n; i++) begin
         sr_write(base + 8'(i));
         if (i != 0) cur_ack = ~cur_ack;
         pb_write(1'b0, cur_ack);
         chk("R9 strobe next cycle after host byte step", sr_irq, 1);
         if (i < DEPTH) exp_byte_q.push_back(base + 8'(i));
      end
      exp_len_q.push_back((n < DEPTH) ? n : DEPTH);
      pb_write(1'b1, cur_ack);
      chk("R4 strobe at end of transfer", sr_irq, 1);
      chk("R4 handoff pulse", pkt_valid, 1);
      repeat (3) @(negedge clk);
   endtask

   // monitor: compares each handed-off packet with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (pkt_valid) begin
            if (exp_len_q.size() == 0) begin
               chk("R4 unexpected packet", 1, 0);
            end else begin
               int e;
               e = exp_len_q.pop_front();
               chk("R3 R4 packet length", 32'(pkt_len), e);
               for (int i = 0; i < e; i++) begin
                  pkt_rd_idx = IDXW'(i);
                  #1;
                  chk("R2 R3 packet byte", pkt_rd_byte, exp_byte_q.pop_front());
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 req_n after reset", req_n, 1);
      chk("R1 sr_q after reset", sr_q, 0);
      chk("R1 sr_irq after reset", sr_irq, 0);
      chk("R1 pkt_valid after reset", pkt_valid, 0);

      // R2 basic host packet
      send_host_packet(3, 8'h10);

      // R2 write with no line change does nothing
      dir_to_engine = 1'b1;
      sr_write(8'h21);
      pb_write(1'b0, cur_ack);
      exp_byte_q.push_back(8'h21);
      pb_write(1'b0, cur_ack);
      chk("R2 unchanged write gives no strobe", sr_irq, 0);
      sr_write(8'h22);
      cur_ack = ~cur_ack;
      pb_write(1'b0, cur_ack);
      exp_byte_q.push_back(8'h22);
      exp_len_q.push_back(2);
      pb_write(1'b1, cur_ack);
      chk("R4 handoff pulse after two bytes", pkt_valid, 1);
      repeat (3) @(negedge clk);

      // R3 overflow: 18 bytes, 16 kept
      send_host_packet(18, 8'h40);

      // R4 zero-byte transfer: no handoff but a strobe
      dir_to_engine = 1'b0;
      pb_write(1'b0, cur_ack);
      chk("R5 empty queue step gives no strobe", sr_irq, 0);
      pb_write(1'b1, cur_ack);
      chk("R4 strobe on empty release", sr_irq, 1);
      chk("R4 no handoff when empty", pkt_valid, 0);

      // R6 request follows acknowledge while idle
      toggle_idle_ack();
      chk("R6 req follows ack", req_n, cur_ack);
      chk("R6 strobe on idle ack change", sr_irq, 1);
      toggle_idle_ack();
      chk("R6 req follows ack back", req_n, cur_ack);

      // R7 R5 R10 response sequence
      rsp_fill(0, 8'hA1); rsp_fill(1, 8'hA2); rsp_fill(2, 8'hA3);
      rsp_go(3);
      chk("R7 req low after load while idle", req_n, 0);
      chk("R10 strobe after load", sr_irq, 1);
      dir_to_engine = 1'b0;
      pb_write(1'b0, cur_ack);
      chk("R5 first byte", sr_q, 8'hA1);
      chk("R5 req still low", req_n, 0);
      cur_ack = ~cur_ack; pb_write(1'b0, cur_ack);
      chk("R5 second byte", sr_q, 8'hA2);
      cur_ack = ~cur_ack; pb_write(1'b0, cur_ack);
      chk("R5 last byte", sr_q, 8'hA3);
      chk("R5 req high after last byte", req_n, 1);
      cur_ack = ~cur_ack; pb_write(1'b0, cur_ack);
      chk("R5 empty queue leaves sr", sr_q, 8'hA3);
      pb_write(1'b1, cur_ack);
      chk("R7 req stays high when queue empty", req_n, 1);
      chk("R4 no handoff after engine transfer", pkt_valid, 0);

      // R7 request reasserted after partial transfer
      rsp_fill(0, 8'hB1); rsp_fill(1, 8'hB2);
      rsp_go(2);
      toggle_idle_ack();
      if (cur_ack == 1'b0) toggle_idle_ack();
      chk("R6 req raised by ack", req_n, 1);
      pb_write(1'b0, cur_ack);
      chk("R5 partial first byte", sr_q, 8'hB1);
      pb_write(1'b1, cur_ack);
      chk("R7 req low with bytes left at end", req_n, 0);

      // R10 reload restarts at entry 0
      rsp_fill(0, 8'hC1);
      rsp_go(1);
      pb_write(1'b0, cur_ack);
      chk("R10 reload reads entry 0", sr_q, 8'hC1);
      chk("R10 single byte is last", req_n, 1);
      pb_write(1'b1, cur_ack);

      // R8 delayed strobe timing
      ddr_b = 8'h00;
      toggle_idle_ack();
      chk("R8 no strobe at once", sr_irq, 0);
      for (int k = 1; k < DLY; k++) begin
         @(negedge clk);
         chk("R8 strobe not early", sr_irq, 0);
      end
      @(negedge clk);
      chk("R8 strobe after delay", sr_irq, 1);
      @(negedge clk);
      chk("R8 strobe one cycle", sr_irq, 0);

      // R8 restart on a second step
      toggle_idle_ack();
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         chk("R8 before restart", sr_irq, 0);
      end
      toggle_idle_ack();
      for (int k = 1; k < DLY; k++) begin
         @(negedge clk);
         chk("R8 restarted delay holds", sr_irq, 0);
      end
      @(negedge clk);
      chk("R8 strobe after restarted delay", sr_irq, 1);

      repeat (2) @(negedge clk);
      chk("R4 all expected packets delivered", exp_len_q.size(), 0);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule